// File: doc/BRIEF.md
# Sequential 64-by-32 Integer Divider with Dividend Fallback

This block divides a 64-bit dividend by a 32-bit divisor and returns a 64-bit quotient. It runs one operation at a time behind a start/busy/done handshake. A mode input selects unsigned or two's-complement signed division. The remainder is computed internally and is not exported.

The two cases that have no defined quotient never raise a fault. A zero divisor, or the most negative 64-bit dividend divided by -1 in signed mode, simply returns the dividend unchanged. Both cases are caught on the start cycle and finish at once. Every other operation runs a 64-step restoring shift-subtract loop on operand magnitudes. In signed mode a sign correction is applied at the end, so the quotient truncates toward zero.

A caller raises `start` for one cycle with the operands valid. It then waits for the one-cycle `done` pulse and reads `result`, which stays valid until the next operation completes.

Top module: `wide_div_unit`

## Requirements
- R1: While reset is held, and on the first cycles after it, `busy` and `done` are 0 and `result` is 0.
- R2: With `signed_mode`=0 and a nonzero divisor, `result` is the unsigned floor of `op_a / op_b`, with `op_b` zero-extended to 64 bits.
- R3: With `signed_mode`=1 and a nonzero divisor, `op_a` and `op_b` are read as two's-complement numbers, and `result` is their quotient truncated toward zero.
- R4: When `op_b` is zero, `result` equals `op_a` in both modes.
- R5: With `signed_mode`=1, `op_a`=0x8000_0000_0000_0000 and `op_b`=0xFFFF_FFFF, `result` equals `op_a`. With `signed_mode`=0 the same pair divides normally, giving 0x8000_0000.
- R6: A special-case operation (R4 or R5) raises `done` in the first cycle after the accepted start edge.
- R7: Any other operation raises `done` in the 65th cycle after the accepted start edge.
- R8: `busy` is 1 from the cycle after an accepted start through the cycle in which `done` is 1. It is 0 in the cycle after `done`.
- R9: `done` is high for exactly one cycle per accepted operation.
- R10: A `start` pulse while `busy` is 1 has no effect: the running operation keeps its operands and result, and no extra `done` follows.
- R11: `result` keeps its value from one `done` until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation when idle |
| signed_mode | input | 1 | 1 selects two's-complement division |
| op_a | input | 64 | Dividend |
| op_b | input | 32 | Divisor |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient, or the dividend in the special cases |

## Verification
The hardest condition to reach from the ports is signed overflow. It needs one exact 64-bit dividend paired with one exact divisor, which uniform random operands practically never produce. Close neighbours such as the minimum dividend over +1, or over -1 in unsigned mode, must take the normal path. The stimulus therefore injects the minimum dividend and an all-ones divisor into part of the random traffic, and adds directed cases that pair the overflow inputs with each mode. A start pulse issued mid-run with different operands exercises the ignore rule.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: magnitudes, quotient sign and special-case detect.
module div_prep #(
  parameter int AW = 64,
  parameter int BW = 32
) (
  input  logic          signed_mode,
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [AW-1:0] a_mag_o,
  output logic [BW-1:0] b_mag_o,
  output logic          neg_q_o,
  output logic          special_o
);
  localparam logic [AW-1:0] A_MIN = {1'b1, {(AW-1){1'b0}}};
  localparam logic [BW-1:0] B_NEG1 = {BW{1'b1}};

  logic a_neg, b_neg, zero_div, ovf;

  always_comb begin
    a_neg     = signed_mode & a_i[AW-1];
    b_neg     = signed_mode & b_i[BW-1];
    a_mag_o   = a_neg ? (~a_i + 1'b1) : a_i;
    b_mag_o   = b_neg ? (~b_i + 1'b1) : b_i;
    neg_q_o   = a_neg ^ b_neg;
    zero_div  = (b_i == '0);
    ovf       = signed_mode & (a_i == A_MIN) & (b_i == B_NEG1);
    special_o = zero_div | ovf;
  end
endmodule

// File: rtl/div_step.sv
// One restoring shift-subtract iteration on magnitudes.
module div_step #(
  parameter int AW = 64,
  parameter int BW = 32
) (
  input  logic [BW:0]   rem_i,
  input  logic [AW-1:0] quo_i,
  input  logic [BW-1:0] dvs_i,
  output logic [BW:0]   rem_o,
  output logic [AW-1:0] quo_o
);
  logic [BW+1:0] shifted;
  logic [BW+1:0] diff;
  logic          fits;

  always_comb begin
    shifted = {rem_i, quo_i[AW-1]};
    diff    = shifted - {2'b00, dvs_i};
    fits    = ~diff[BW+1];
    rem_o   = fits ? diff[BW:0] : shifted[BW:0];
    quo_o   = {quo_i[AW-2:0], fits};
  end
endmodule

// File: rtl/div_fix.sv
// Final sign correction of the unsigned quotient.
module div_fix #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] q_i,
  input  logic          neg_i,
  output logic [AW-1:0] q_o
);
  always_comb q_o = neg_i ? (~q_i + 1'b1) : q_i;
endmodule

// File: rtl/wide_div_unit.sv
module wide_div_unit
  import div_pkg::*;
#(
  parameter int AW = 64,
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          signed_mode,
  input  logic [AW-1:0] op_a,
  input  logic [BW-1:0] op_b,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] result
);
  localparam int CNT_W = $clog2(AW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(AW - 1);

  // reset synchronizer: asserts asynchronously, releases on clock
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  div_state_e      state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [BW:0]     rem_q, rem_n;
  logic [AW-1:0]   quo_q, quo_n;
  logic [BW-1:0]   dvs_q, dvs_n;
  logic            neg_q, neg_n;
  logic [AW-1:0]   res_q, res_n;
  logic            ld_work, ld_res;

  logic [AW-1:0] a_mag;
  logic [BW-1:0] b_mag;
  logic          neg_in, special;
  logic [BW:0]   step_rem;
  logic [AW-1:0] step_quo, fixed_q;

  div_prep #(.AW(AW), .BW(BW)) u_prep (
    .signed_mode (signed_mode),
    .a_i         (op_a),
    .b_i         (op_b),
    .a_mag_o     (a_mag),
    .b_mag_o     (b_mag),
    .neg_q_o     (neg_in),
    .special_o   (special)
  );

  div_step #(.AW(AW), .BW(BW)) u_step (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .dvs_i (dvs_q),
    .rem_o (step_rem),
    .quo_o (step_quo)
  );

  div_fix #(.AW(AW)) u_fix (
    .q_i   (step_quo),
    .neg_i (neg_q),
    .q_o   (fixed_q)
  );

  // next-state logic
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    rem_n   = rem_q;
    quo_n   = quo_q;
    dvs_n   = dvs_q;
    neg_n   = neg_q;
    res_n   = res_q;
    ld_work = 1'b0;
    ld_res  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (special) begin
            res_n   = op_a;
            ld_res  = 1'b1;
            state_n = ST_FIN;
          end else begin
            rem_n   = '0;
            quo_n   = a_mag;
            dvs_n   = b_mag;
            neg_n   = neg_in;
            cnt_n   = '0;
            ld_work = 1'b1;
            state_n = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        rem_n   = step_rem;
        quo_n   = step_quo;
        cnt_n   = cnt_q + 1'b1;
        ld_work = 1'b1;
        if (cnt_q == LAST) begin
          res_n   = fixed_q;
          ld_res  = 1'b1;
          state_n = ST_FIN;
        end
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      neg_q <= 1'b0;
    end else if (ld_work) begin
      cnt_q <= cnt_n;
      rem_q <= rem_n;
      quo_q <= quo_n;
      dvs_q <= dvs_n;
      neg_q <= neg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_q <= '0;
    end else if (ld_res) begin
      res_q <= res_n;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_FIN);
  assign result = res_q;

  // assertions
  a_r4_zero_returns_a: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && !busy && op_b == '0) |=> (done && result == $past(op_a)));

  a_r5_overflow_returns_a: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && !busy && signed_mode && op_a == {1'b1, {(AW-1){1'b0}}} && op_b == {BW{1'b1}})
      |=> (done && result == $past(op_a)));

  a_r8_busy_covers_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  a_r10_run_continues: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && !done) |=> busy);

  a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!done && $past(!done)) |-> $stable(result));
endmodule

// File: tb/tb_wide_div_unit.sv
module tb_wide_div_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] A_MIN = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [63:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        busy, done;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;

  wide_div_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] a, input logic [31:0] b, input logic sm);
    longint sa, sb;
    if (b == 32'd0) return a;
    if (sm) begin
      if (a == A_MIN && b == 32'hFFFF_FFFF) return a;
      sa = a;
      sb = {{32{b[31]}}, b};
      return 64'(sa / sb);
    end
    return a / {32'd0, b};
  endfunction

  function automatic bit is_special(input logic [63:0] a, input logic [31:0] b, input logic sm);
    return (b == 32'd0) || (sm && a == A_MIN && b == 32'hFFFF_FFFF);
  endfunction

  // Run one op; optionally inject a start with other operands at cycle inj_at.
  task automatic run_op(input logic [63:0] a, input logic [31:0] b, input logic sm,
                        input string req, input int inj_at);
    logic [63:0] exp;
    int lat;
    bit busy_ok;
    exp = model(a, b, sm);
    @(negedge clk);
    op_a = a; op_b = b; signed_mode = sm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a = ~a; op_b = b ^ 32'h5A5A_0F0F; signed_mode = ~sm;
    lat = 1;
    busy_ok = 1'b1;
    while (!done && lat < 200) begin
      if (!busy) busy_ok = 1'b0;
      if (lat == inj_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(result == exp, {req, " result"}, result, exp);
    chk(lat == (is_special(a, b, sm) ? 1 : 65),
        is_special(a, b, sm) ? "R6 latency" : "R7 latency",
        64'(lat), 64'(is_special(a, b, sm) ? 1 : 65));
    chk(busy_ok && busy, "R8 busy during op", 64'(busy_ok), 64'd1);
    @(negedge clk);
    chk(!done, "R9 done one cycle", 64'(done), 64'd0);
    chk(!busy, "R8 busy low after done", 64'(busy), 64'd0);
    chk(result == exp, "R11 result held", result, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 64'd0, "R1 reset state", {busy, done, result[61:0]}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && result == 64'd0, "R1 after release", {busy, done, result[61:0]}, 64'd0);

    // R2 unsigned directed
    run_op(64'd1000, 32'd7, 1'b0, "R2 small", 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 32'd1, 1'b0, "R2 div by one", 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2 max divisor", 0);
    run_op(64'd5, 32'd9, 1'b0, "R2 quotient zero", 0);
    // R3 signed directed, all sign combinations
    run_op(64'd100, 32'd7, 1'b1, "R3 pos/pos", 0);
    run_op(-64'sd100, 32'd7, 1'b1, "R3 neg/pos", 0);
    run_op(64'd100, -32'sd7, 1'b1, "R3 pos/neg", 0);
    run_op(-64'sd100, -32'sd7, 1'b1, "R3 neg/neg", 0);
    run_op(A_MIN, 32'd1, 1'b1, "R3 min over one", 0);
    run_op(A_MIN, 32'h8000_0000, 1'b1, "R3 min over min32", 0);
    run_op(A_MIN, 32'hFFFF_FFFE, 1'b1, "R3 min over -2", 0);
    // R4 zero divisor
    run_op(64'h1234_5678_9ABC_DEF0, 32'd0, 1'b0, "R4 zero unsigned", 0);
    run_op(64'hFEDC_BA98_7654_3210, 32'd0, 1'b1, "R4 zero signed", 0);
    // R5 overflow and its unsigned twin
    run_op(A_MIN, 32'hFFFF_FFFF, 1'b1, "R5 overflow signed", 0);
    run_op(A_MIN, 32'hFFFF_FFFF, 1'b0, "R5 same pair unsigned", 0);
    // R10 start while busy is ignored
    run_op(64'd987654321987, 32'd12345, 1'b0, "R10 ignored start early", 3);
    run_op(-64'sd55555555555, 32'd333, 1'b1, "R10 ignored start late", 60);

    // random mix
    for (int n = 0; n < 250; n++) begin
      logic [63:0] a;
      logic [31:0] b;
      logic sm;
      int kind;
      a = {$urandom, $urandom};
      b = $urandom;
      sm = 1'($urandom);
      kind = int'($urandom % 16);
      if (kind == 0) b = 32'd0;
      else if (kind == 1) begin a = A_MIN; b = 32'hFFFF_FFFF; end
      else if (kind < 5) b = b & 32'hFF;
      else if (kind == 5) b = 32'hFFFF_FFFF;
      else if (kind == 6) a = A_MIN;
      run_op(a, b, sm, sm ? "R3 random" : "R2 random", 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule